// File: doc/BRIEF.md
# Subtract-and-Branch Single-Instruction Processor

This block is a small processor with one instruction. Each instruction is three consecutive memory words: an operand address `a`, an operand address `b` and a branch target. The core reads both operands, stores `Mem[b] - Mem[a]` back into `Mem[b]`, and then branches to the target if the stored value is zero or negative. If the value is positive, it steps to the next instruction. Clearing a word, jumping unconditionally and adding one word into another are all built from short sequences of this one operation, using a scratch word that holds zero.

Code and data share one internal synchronous memory. The memory is filled through a load port while the core is stopped, and it can be inspected at any time through a registered debug read port. Raising `run` starts execution at address 0. When a taken branch names the reserved all-ones target, the core raises `halted` and stops. Lowering `run` returns the core to its idle state.

Top module: `subneg_cpu`

## Requirements
- R1: After reset, `halted` is low and the core is idle with its program counter at 0.
- R2: While `run` is low, a cycle with `load_en` high writes `load_data` into the word at `load_addr`. The debug port returns the word at `dbg_addr` on `dbg_data` one clock after the address is presented.
- R3: While `run` is high, `load_en` is ignored and memory is unchanged by the load port.
- R4: The instruction at program counter `p` is taken from word `p` (address `a`), word `p+1` (address `b`) and word `p+2` (target). The core writes `Mem[b] - Mem[a]`, modulo 2^DATA_W, into `Mem[b]`. Operand addresses use the low ADDR_W bits of their words.
- R5: When the written result, read as a signed two's-complement value, is zero or negative, the next instruction is fetched from the target address.
- R6: When the written result is positive, the next instruction is fetched from `p+3`, wrapping modulo 2^ADDR_W.
- R7: A taken branch whose target word is all ones (0xFFFF at default width) sets `halted`. The core then performs no further memory writes while `run` stays high. An all-ones target on a positive result does not halt.
- R8: Lowering `run` clears `halted` and resets the program counter to 0 one clock later. A new rising `run` re-executes the program from address 0.
- R9: The sign test uses the wrapped result, so 0x8000 minus 1 gives 0x7FFF, which is positive and does not branch.
- R10: Each instruction takes exactly 7 clocks. After `run` is first seen high, a program that executes N instructions raises `halted` after 7N+1 rising edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | High to execute; low holds the core idle at address 0 |
| load_en | input | 1 | Write strobe for the load port (honoured only while run is low) |
| load_addr | input | ADDR_W | Word address for the load port |
| load_data | input | DATA_W | Word to write through the load port |
| dbg_addr | input | ADDR_W | Word address for the debug read port |
| dbg_data | output | DATA_W | Registered memory word at dbg_addr |
| halted | output | 1 | High once the halt target has been taken |

## Verification
The bench builds the core with its default widths: 16-bit words and 8-bit addresses, which gives a 256-word memory. These widths let it reach the signed overflow corner at 0x8000, the 0xFFFF halt target, and programs large enough to hold the clear, jump and three-step add idioms next to a data region. Random forward-branching programs are compared against a bench model. The model supplies both the final data words and the expected number of clocks to halt.

// File: rtl/sbn_pkg.sv
package sbn_pkg;

    // Phases of one instruction, plus idle and halt.
    typedef enum logic [3:0] {
        ST_IDLE  = 4'd0,
        ST_FETA  = 4'd1,
        ST_FETB  = 4'd2,
        ST_FETT  = 4'd3,
        ST_RDA   = 4'd4,
        ST_RDB   = 4'd5,
        ST_WBK   = 4'd6,
        ST_NPC   = 4'd7,
        ST_HALT  = 4'd8
    } sbn_state_e;

endpackage

// File: rtl/sbn_alu.sv
module sbn_alu #(
    parameter int DATA_W = 16
) (
    input  logic [DATA_W-1:0] minuend,
    input  logic [DATA_W-1:0] subtrahend,
    output logic [DATA_W-1:0] diff,
    output logic              not_pos
);

    always_comb begin
        diff    = minuend - subtrahend;
        not_pos = diff[DATA_W-1] | (diff == '0);
    end

endmodule

// File: rtl/sbn_mem.sv
module sbn_mem #(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic [ADDR_W-1:0] core_addr,
    input  logic              core_we,
    input  logic [DATA_W-1:0] core_wdata,
    output logic [DATA_W-1:0] core_rdata,
    input  logic              ld_we,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic [DATA_W-1:0] ld_wdata,
    input  logic [ADDR_W-1:0] peek_addr,
    output logic [DATA_W-1:0] peek_rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
        if (core_we) begin
            store[core_addr] <= core_wdata;
        end else if (ld_we) begin
            store[ld_addr] <= ld_wdata;
        end
        core_rdata <= store[core_addr];
        peek_rdata <= store[peek_addr];
    end

endmodule

// File: rtl/subneg_cpu.sv
module subneg_cpu
    import sbn_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              load_en,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic [DATA_W-1:0] load_data,
    input  logic [ADDR_W-1:0] dbg_addr,
    output logic [DATA_W-1:0] dbg_data,
    output logic              halted
);

    localparam logic [ADDR_W-1:0] STEP     = ADDR_W'(3);
    localparam logic [ADDR_W-1:0] ONE      = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] TWO      = ADDR_W'(2);
    localparam logic [DATA_W-1:0] STOP_TGT = {DATA_W{1'b1}};

    typedef struct packed {
        sbn_state_e        state;
        logic [ADDR_W-1:0] pc;
        logic [ADDR_W-1:0] opa;
        logic [ADDR_W-1:0] opb;
        logic [DATA_W-1:0] tgt;
        logic [DATA_W-1:0] va;
        logic              le;
    } core_t;

    core_t cur_q, cur_d;

    logic [ADDR_W-1:0] mem_addr;
    logic              mem_we;
    logic [DATA_W-1:0] mem_wdata;
    logic [DATA_W-1:0] mem_rdata;
    logic              ld_ok;
    logic [DATA_W-1:0] alu_diff;
    logic              alu_le;

    assign ld_ok = load_en & ~run;

    sbn_mem #(
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W)
    ) u_mem (
        .clk        (clk),
        .core_addr  (mem_addr),
        .core_we    (mem_we),
        .core_wdata (mem_wdata),
        .core_rdata (mem_rdata),
        .ld_we      (ld_ok),
        .ld_addr    (load_addr),
        .ld_wdata   (load_data),
        .peek_addr  (dbg_addr),
        .peek_rdata (dbg_data)
    );

    sbn_alu #(
        .DATA_W (DATA_W)
    ) u_alu (
        .minuend    (mem_rdata),
        .subtrahend (cur_q.va),
        .diff       (alu_diff),
        .not_pos    (alu_le)
    );

    always_comb begin
        cur_d     = cur_q;
        mem_addr  = cur_q.pc;
        mem_we    = 1'b0;
        mem_wdata = alu_diff;
        if (!run) begin
            cur_d.state = ST_IDLE;
            cur_d.pc    = '0;
        end else begin
            unique case (cur_q.state)
                ST_IDLE: begin
                    cur_d.state = ST_FETA;
                end
                ST_FETA: begin
                    mem_addr    = cur_q.pc;
                    cur_d.state = ST_FETB;
                end
                ST_FETB: begin
                    mem_addr    = cur_q.pc + ONE;
                    cur_d.opa   = mem_rdata[ADDR_W-1:0];
                    cur_d.state = ST_FETT;
                end
                ST_FETT: begin
                    mem_addr    = cur_q.pc + TWO;
                    cur_d.opb   = mem_rdata[ADDR_W-1:0];
                    cur_d.state = ST_RDA;
                end
                ST_RDA: begin
                    mem_addr    = cur_q.opa;
                    cur_d.tgt   = mem_rdata;
                    cur_d.state = ST_RDB;
                end
                ST_RDB: begin
                    mem_addr    = cur_q.opb;
                    cur_d.va    = mem_rdata;
                    cur_d.state = ST_WBK;
                end
                ST_WBK: begin
                    mem_addr    = cur_q.opb;
                    mem_we      = 1'b1;
                    cur_d.le    = alu_le;
                    cur_d.state = ST_NPC;
                end
                ST_NPC: begin
                    if (cur_q.le) begin
                        if (cur_q.tgt == STOP_TGT) begin
                            cur_d.state = ST_HALT;
                        end else begin
                            cur_d.pc    = cur_q.tgt[ADDR_W-1:0];
                            cur_d.state = ST_FETA;
                        end
                    end else begin
                        cur_d.pc    = cur_q.pc + STEP;
                        cur_d.state = ST_FETA;
                    end
                end
                ST_HALT: begin
                    cur_d.state = ST_HALT;
                end
                default: begin
                    cur_d.state = ST_IDLE;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '{state: ST_IDLE, pc: '0, opa: '0, opb: '0,
                       tgt: '0, va: '0, le: 1'b0};
        end else begin
            cur_q <= cur_d;
        end
    end

    assign halted = (cur_q.state == ST_HALT);

endmodule

// File: rtl/subneg_cpu_chk.sv
module subneg_cpu_chk
    import sbn_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              run,
    input logic              halted,
    input sbn_state_e        state,
    input logic [ADDR_W-1:0] pc,
    input logic [DATA_W-1:0] tgt,
    input logic              le,
    input logic              mem_we
);

    localparam logic [DATA_W-1:0] STOP_TGT = {DATA_W{1'b1}};

    p_abort_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (!halted && pc == '0));

    p_halt_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (halted && run) |=> halted);

    p_halt_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> !mem_we);

    p_halt_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(halted) |-> (le && tgt == STOP_TGT));

    p_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (run && state == ST_NPC && !le) |=> (pc == ADDR_W'($past(pc) + ADDR_W'(3))));

    p_branch_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (run && state == ST_NPC && le && tgt != STOP_TGT)
            |=> (pc == $past(tgt[ADDR_W-1:0])));

endmodule

bind subneg_cpu subneg_cpu_chk #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W)
) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (run),
    .halted (halted),
    .state  (cur_q.state),
    .pc     (cur_q.pc),
    .tgt    (cur_q.tgt),
    .le     (cur_q.le),
    .mem_we (mem_we)
);

// File: tb/subneg_cpu_tb.sv
`timescale 1ns/1ps
module subneg_cpu_tb;

    localparam int DW = 16;
    localparam int AW = 8;
    localparam int NW = 1 << AW;
    localparam logic [DW-1:0] HALT_T = 16'hFFFF;
    localparam int ZW = 250;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          run = 1'b0;
    logic          load_en = 1'b0;
    logic [AW-1:0] load_addr = '0;
    logic [DW-1:0] load_data = '0;
    logic [AW-1:0] dbg_addr = '0;
    logic [DW-1:0] dbg_data;
    logic          halted;

    int n_checks = 0;
    int n_fail   = 0;

    logic [DW-1:0] mdl [NW];

    always #4 clk = ~clk;

    subneg_cpu #(.DATA_W(DW), .ADDR_W(AW)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .load_en   (load_en),
        .load_addr (load_addr),
        .load_data (load_data),
        .dbg_addr  (dbg_addr),
        .dbg_data  (dbg_data),
        .halted    (halted)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d (0x%0h) expected=%0d (0x%0h)", req, act, act, exp, exp);
        end
    endtask

    task automatic put(input int a, input logic [DW-1:0] d);
        @(negedge clk);
        load_en = 1'b1; load_addr = AW'(a); load_data = d;
        mdl[a] = d;
        @(negedge clk);
        load_en = 1'b0;
    endtask

    task automatic peek(input int a, output logic [DW-1:0] d);
        @(negedge clk);
        dbg_addr = AW'(a);
        @(posedge clk);
        @(negedge clk);
        d = dbg_data;
    endtask

    task automatic put_ins(input int at, input int a, input int b, input logic [DW-1:0] t);
        put(at, DW'(a)); put(at + 1, DW'(b)); put(at + 2, t);
    endtask

    // Reference execution on the bench copy; returns instructions executed.
    function automatic int model_exec();
        int pc = 0;
        int n = 0;
        for (int k = 0; k < 5000; k++) begin
            logic [DW-1:0] a, b, t, r;
            a = mdl[pc]; b = mdl[(pc + 1) % NW]; t = mdl[(pc + 2) % NW];
            r = mdl[b[AW-1:0]] - mdl[a[AW-1:0]];
            mdl[b[AW-1:0]] = r;
            n++;
            if ($signed(r) <= 0) begin
                if (t == HALT_T) return n;
                pc = int'(t[AW-1:0]);
            end else begin
                pc = (pc + 3) % NW;
            end
        end
        return -1;
    endfunction

    // Start, optionally poke the load port mid-run (R3), return edges to halt.
    task automatic go(input bit poke, output int edges);
        @(negedge clk);
        run = 1'b1;
        edges = 0;
        for (int k = 0; k < 4000; k++) begin
            @(posedge clk);
            @(negedge clk);
            edges++;
            if (poke && edges == 5) begin
                load_en = 1'b1; load_addr = AW'(245); load_data = 16'hBEEF;
            end else begin
                load_en = 1'b0;
            end
            if (halted) break;
        end
        load_en = 1'b0;
        if (!halted) check(1'b0, "R10 halt timeout", edges, -1);
    endtask

    task automatic stop_run();
        @(negedge clk);
        run = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check(halted == 1'b0, "R8 halted cleared after run low", int'(halted), 0);
    endtask

    initial begin
        #(8 * 200000);
        check(1'b0, "watchdog", 0, 1);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        logic [DW-1:0] d;
        int edges, n_exp;
        int exp_words [int];
        void'($urandom(32'd4242));
        for (int i = 0; i < NW; i++) mdl[i] = '0;

        repeat (3) @(negedge clk);
        check(halted == 1'b0, "R1 halted low in reset", int'(halted), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(halted == 1'b0, "R1 halted low after reset", int'(halted), 0);

        // R2: load then read back
        put(246, 16'hA5C3);
        peek(246, d);
        check(d == 16'hA5C3, "R2 load/debug readback", int'(d), 16'hA5C3);
        put(247, 16'h0001);
        peek(247, d);
        check(d == 16'h0001, "R2 second readback", int'(d), 1);

        // Directed: clear, jump, add, wrap, halt
        put(200, 16'd1234); put(201, 16'd100); put(202, 16'd77);
        put(203, 16'd5); put(204, 16'h8000); put(205, 16'd1); put(ZW, 16'd0);
        put_ins(0, 202, 202, 16'd3);      // clear C
        put_ins(3, ZW, ZW, 16'd9);        // jump to 9
        put_ins(6, 203, 203, 16'd9);      // skipped
        put_ins(9, 200, ZW, 16'd12);      // Z -= A
        put_ins(12, ZW, 201, 16'd15);     // B -= Z
        put_ins(15, ZW, ZW, 16'd18);      // Z = 0
        put_ins(18, 205, 204, HALT_T);    // wrap, positive, no halt
        put_ins(21, ZW, ZW, HALT_T);      // halt
        go(1'b0, edges);
        check(edges == 50, "R10 directed cycles", edges, 50);
        peek(202, d); check(d == 16'd0, "R4 clear idiom", int'(d), 0);
        peek(203, d); check(d == 16'd5, "R5 jump skipped instruction", int'(d), 5);
        peek(201, d); check(d == 16'd1334, "R4 add idiom", int'(d), 1334);
        peek(ZW, d);  check(d == 16'd0, "R4 scratch cleared", int'(d), 0);
        peek(200, d); check(d == 16'd1234, "R4 source unchanged", int'(d), 1234);
        peek(204, d); check(d == 16'h7FFF, "R9 wrap result", int'(d), 16'h7FFF);
        peek(21, d);  check(d == DW'(ZW), "R4 code intact", int'(d), ZW);
        repeat (4) @(negedge clk);
        check(halted == 1'b1, "R7 halt holds", int'(halted), 1);
        peek(201, d); check(d == 16'd1334, "R7 no writes while halted", int'(d), 1334);

        // R8: rerun from address 0
        stop_run();
        go(1'b0, edges);
        check(edges == 50, "R8 rerun cycles", edges, 50);
        peek(201, d); check(d == 16'd2568, "R8 rerun add", int'(d), 2568);
        peek(204, d); check(d == 16'h7FFE, "R8 R9 rerun wrap", int'(d), 16'h7FFE);
        stop_run();

        // Random forward-branching programs vs bench model
        for (int round = 0; round < 4; round++) begin
            int k;
            k = 4 + int'($urandom % 7);
            for (int i = 200; i < 240; i++) begin
                logic [DW-1:0] v;
                case ($urandom % 4)
                    0: v = 16'h8000;
                    1: v = 16'd0;
                    default: v = DW'($urandom);
                endcase
                put(i, v);
            end
            put(ZW, 16'd0);
            put(245, 16'h1234);
            for (int i = 0; i < k; i++) begin
                int a, b;
                logic [DW-1:0] t;
                a = 200 + int'($urandom % 40);
                b = 200 + int'($urandom % 40);
                t = ($urandom % 2 == 0) ? DW'(3 * i + 3) : DW'(3 * i + 6);
                put_ins(3 * i, a, b, t);
            end
            put_ins(3 * k, ZW, ZW, HALT_T);
            put_ins(3 * k + 3, ZW, ZW, HALT_T);
            n_exp = model_exec();
            go(round == 0, edges);
            check(edges == 7 * n_exp + 1, "R10 random cycles", edges, 7 * n_exp + 1);
            for (int i = 200; i < 240; i++) begin
                peek(i, d);
                check(d == mdl[i], "R4 R5 R6 random data word", int'(d), int'(mdl[i]));
            end
            peek(245, d);
            check(d == 16'h1234, "R3 load ignored while running", int'(d), 16'h1234);
            stop_run();
        end

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule